// File: doc/BRIEF.md
# Subword-Partitioned Masked Vector Add/Subtract Unit

This unit runs element-wise addition or subtraction between two registers of a small vector register file and stores the result in a third register. There are eight registers of 2048 bits each. Each instruction picks 16-, 32- or 64-bit elements. The datapath is four 64-bit pipes wide, 256 bits in all. Its carry chain is cut at element boundaries, so one cycle handles sixteen, eight or four elements.

An instruction arrives through a valid/ready handshake. It carries an operation, an element width, a vector length, a destination index, two source indices and a mask enable. The unit then walks the vector one 256-bit chunk per cycle. Elements at or past the vector length keep their old value, and so do masked-off elements, which are set by a 128-bit flag register. When the walk ends the unit pulses `done`. A test port loads register words and the flag register while the unit is idle, and reads any 64-bit register word at any time.

Top module: `vlane_addsub`

## Requirements
- R1: Width code `in_width` 0 selects 16-bit elements, 1 selects 32-bit elements, and 2 or 3 select 64-bit elements. Element i of a register occupies bits [i*w +: w]. `in_op` 0 gives vd[i] = vs1[i] + vs2[i] and `in_op` 1 gives vd[i] = vs1[i] - vs2[i], both modulo 2^w.
- R2: No carry or borrow passes from one element into the next. Within a 64-bit element it still propagates across all four 16-bit segments.
- R3: A requested length above 2048/w is clamped to 2048/w, which is 128, 64 or 32 elements.
- R4: An element whose index is at or above the effective length is not written. This includes the unused lanes of a final partial chunk.
- R5: With `in_masked`=1, element i is written only if flag bit i is 1. With `in_masked`=0 the flags have no effect.
- R6: After the accepting edge the unit stays busy for max(1, ceil(len/L)) cycles, where L is 16, 8 or 4 for the three widths. `done` is high for exactly the one cycle after the last busy cycle.
- R7: An instruction is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the `done` cycle, when it returns high. `in_valid` has no effect while `in_ready` is low.
- R8: `tp_rdata` always shows bits [tp_word*64 +: 64] of register `tp_reg`. `tp_we` writes such a word and `tp_flag_we` writes the flag register, but only while `in_ready` is high. Test-port writes made while busy are dropped.
- R9: The destination may equal a source. The result then uses the source values from before the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit idle, instruction can be taken |
| in_op | input | 1 | 0 add, 1 subtract |
| in_width | input | 2 | Element width code |
| in_vlen | input | 8 | Requested element count |
| in_vd | input | 3 | Destination register |
| in_vs1 | input | 3 | First source register |
| in_vs2 | input | 3 | Second source register |
| in_masked | input | 1 | Gate writes with the flag register |
| done | output | 1 | One-cycle completion pulse |
| tp_we | input | 1 | Test-port word write |
| tp_reg | input | 3 | Test-port register select |
| tp_word | input | 5 | Test-port 64-bit word select |
| tp_wdata | input | 64 | Test-port write data |
| tp_rdata | output | 64 | Test-port read data |
| tp_flag_we | input | 1 | Flag register write |
| tp_flag_wdata | input | 128 | Flag register write data |

## Verification
A wrong chunk counter or latched length appears first in the timing of `done`. It fires early or late by a whole cycle, which the per-cycle model catches immediately. A broken carry cut or a bad lane enable leaves no trace in the handshake. It shows up only when the affected 64-bit words are read back after the instruction, so every register is swept after each instruction. Stimulus that straddles 16-bit segments with all-ones data makes a misplaced carry cut show in the very first word of the destination.

// File: rtl/vlane_addsub.sv
module vlane_addsub #(
  parameter int NREG  = 8,
  parameter int VBITS = 2048,
  parameter int NPIPE = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_op,
  input  logic [1:0]                  in_width,
  input  logic [$clog2(VBITS/16):0]   in_vlen,
  input  logic [$clog2(NREG)-1:0]     in_vd,
  input  logic [$clog2(NREG)-1:0]     in_vs1,
  input  logic [$clog2(NREG)-1:0]     in_vs2,
  input  logic                        in_masked,
  output logic                        done,
  input  logic                        tp_we,
  input  logic [$clog2(NREG)-1:0]     tp_reg,
  input  logic [$clog2(VBITS/64)-1:0] tp_word,
  input  logic [63:0]                 tp_wdata,
  output logic [63:0]                 tp_rdata,
  input  logic                        tp_flag_we,
  input  logic [VBITS/16-1:0]         tp_flag_wdata
);
  localparam int RW     = $clog2(NREG);
  localparam int WORDS  = VBITS / 64;
  localparam int FLAGW  = VBITS / 16;
  localparam int EW     = $clog2(FLAGW);
  localparam int LW     = EW + 1;
  localparam int CH     = NPIPE * 64;
  localparam int NSEG   = CH / 16;
  localparam int NCHUNK = VBITS / CH;
  localparam int CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam int NPB    = $clog2(NPIPE);

  logic [VBITS-1:0] rf [NREG];
  logic [FLAGW-1:0] flags;

  logic          busy, op_q, msk_q;
  logic [1:0]    sh_q;
  logic [LW-1:0] vl_q;
  logic [RW-1:0] vd_q, vs1_q, vs2_q;
  logic [CW-1:0] cnt, last_q;

  // shift: 2 for 16-bit, 1 for 32-bit, 0 for 64-bit elements
  logic [1:0]    sh_in;
  logic [LW-1:0] maxl_in, vl_in;
  logic [LW:0]   nch_in;
  logic [CW-1:0] last_in;

  assign sh_in   = (in_width == 2'd0) ? 2'd2 : (in_width == 2'd1) ? 2'd1 : 2'd0;
  assign maxl_in = LW'(WORDS) << sh_in;
  assign vl_in   = (in_vlen > maxl_in) ? maxl_in : in_vlen;
  assign nch_in  = ({1'b0, vl_in} + ((LW+1)'(NPIPE) << sh_in) - (LW+1)'(1)) >> (NPB + int'(sh_in));
  assign last_in = (nch_in == '0) ? '0 : CW'(nch_in - (LW+1)'(1));

  assign in_ready = !busy;
  assign tp_rdata = rf[tp_reg][int'(tp_word)*64 +: 64];

  logic [CH-1:0]   a, b, old, sum, nw;
  logic [NSEG-1:0] cy;

  assign a   = rf[vs1_q][int'(cnt)*CH +: CH];
  assign b   = rf[vs2_q][int'(cnt)*CH +: CH];
  assign old = rf[vd_q][int'(cnt)*CH +: CH];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic        cin, en;
    logic [15:0] eidx;
    if (s == 0) begin : g_head
      assign cin = op_q;
    end else begin : g_link
      logic start;
      assign start = (sh_q == 2'd2) || (sh_q == 2'd1 && (s % 2 == 0)) || (s % 4 == 0);
      assign cin   = start ? op_q : cy[s-1];
    end
    assign {cy[s], sum[s*16 +: 16]} = {1'b0, a[s*16 +: 16]}
                                    + {1'b0, b[s*16 +: 16] ^ {16{op_q}}}
                                    + 17'(cin);
    assign eidx = 16'(cnt) * (16'(NPIPE) << sh_q) + (16'(s) >> (2'd2 - sh_q));
    assign en   = (eidx < 16'(vl_q)) && (!msk_q || flags[eidx[EW-1:0]]);
    assign nw[s*16 +: 16] = en ? sum[s*16 +: 16] : old[s*16 +: 16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      last_q <= '0;
      op_q   <= 1'b0;
      msk_q  <= 1'b0;
      sh_q   <= 2'd0;
      vl_q   <= '0;
      vd_q   <= '0;
      vs1_q  <= '0;
      vs2_q  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          busy   <= 1'b1;
          cnt    <= '0;
          last_q <= last_in;
          op_q   <= in_op;
          msk_q  <= in_masked;
          sh_q   <= sh_in;
          vl_q   <= vl_in;
          vd_q   <= in_vd;
          vs1_q  <= in_vs1;
          vs2_q  <= in_vs2;
        end
      end else if (cnt == last_q) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy)
      rf[vd_q][int'(cnt)*CH +: CH] <= nw;
    else if (tp_we)
      rf[tp_reg][int'(tp_word)*64 +: 64] <= tp_wdata;
  end

  always_ff @(posedge clk) begin
    if (!busy && tp_flag_we) flags <= tp_flag_wdata;
  end
endmodule

module vlane_addsub_chk #(
  parameter int RW = 3,
  parameter int WW = 5,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_width,
  input logic [LW-1:0] in_vlen,
  input logic          done,
  input logic          tp_we,
  input logic [RW-1:0] tp_reg,
  input logic [WW-1:0] tp_word,
  input logic [63:0]   tp_rdata
);
  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_follows_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!in_ready));

  assert_ready_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  assert_one_chunk_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_vlen == '0 || (in_width == 2'd0 && in_vlen <= LW'(16)))
    |=> ##1 done);

  assert_idle_read_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && $past(in_ready) && !$past(tp_we) && $stable(tp_reg) && $stable(tp_word)
    |-> $stable(tp_rdata));
endmodule

bind vlane_addsub vlane_addsub_chk #(.RW(RW), .WW($clog2(WORDS)), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_width(in_width), .in_vlen(in_vlen), .done(done), .tp_we(tp_we),
  .tp_reg(tp_reg), .tp_word(tp_word), .tp_rdata(tp_rdata)
);

// File: tb/tb_vlane_addsub.sv
module tb_vlane_addsub;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_op = 0, in_masked = 0;
  logic [1:0] in_width = 0;
  logic [7:0] in_vlen = 0;
  logic [2:0] in_vd = 0, in_vs1 = 0, in_vs2 = 0, tp_reg = 0;
  logic [4:0] tp_word = 0;
  logic tp_we = 0, tp_flag_we = 0;
  logic [63:0] tp_wdata = 0;
  logic [127:0] tp_flag_wdata = 0;
  logic in_ready, done;
  logic [63:0] tp_rdata;

  int checks = 0, fails = 0;

  logic [2047:0] m [8];
  logic [127:0]  mflag;

  vlane_addsub dut (.*);

  always #5 clk = ~clk;

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tp_write(input int r, input int w, input logic [63:0] v);
    @(negedge clk);
    tp_we = 1; tp_reg = 3'(r); tp_word = 5'(w); tp_wdata = v;
    @(negedge clk);
    tp_we = 0;
    m[r][w*64 +: 64] = v;
  endtask

  task automatic flag_write(input logic [127:0] f);
    @(negedge clk);
    tp_flag_we = 1; tp_flag_wdata = f;
    @(negedge clk);
    tp_flag_we = 0;
    mflag = f;
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < 8; r++)
      for (int w = 0; w < 32; w++) begin
        @(negedge clk);
        tp_reg = 3'(r); tp_word = 5'(w);
        #1;
        chk(tp_rdata === m[r][w*64 +: 64], req, tp_rdata, m[r][w*64 +: 64]);
      end
  endtask

  task automatic model(input bit op, input int wc, input int len, input int d,
                       input int s1, input int s2, input bit msk);
    int w;
    int mx;
    int vl;
    logic [2047:0] a, b, dv, x, y;
    logic [63:0] mask, r;
    w  = (wc == 0) ? 16 : (wc == 1) ? 32 : 64;
    mx = 2048 / w;
    vl = (len > mx) ? mx : len;
    mask = (w == 64) ? '1 : ((64'h1 << w) - 64'h1);
    a = m[s1]; b = m[s2]; dv = m[d];
    for (int e = 0; e < vl; e++) begin
      if (!msk || mflag[e]) begin
        x = a >> (e * w);
        y = b >> (e * w);
        r = op ? (x[63:0] - y[63:0]) : (x[63:0] + y[63:0]);
        r = r & mask;
        dv = (dv & ~({1984'b0, mask} << (e * w))) | ({1984'b0, r} << (e * w));
      end
    end
    m[d] = dv;
  endtask

  task automatic run(input bit op, input int wc, input int len, input int d,
                     input int s1, input int s2, input bit msk, input bit disturb,
                     input string req);
    int lanes, mx, vl, n;
    lanes = (wc == 0) ? 16 : (wc == 1) ? 8 : 4;
    mx    = (wc == 0) ? 128 : (wc == 1) ? 64 : 32;
    vl    = (len > mx) ? mx : len;
    n     = (vl == 0) ? 1 : (vl + lanes - 1) / lanes;
    @(negedge clk);
    chk(in_ready === 1'b1, "R7", 64'(in_ready), 64'd1);
    in_valid = 1; in_op = op; in_width = 2'(wc); in_vlen = 8'(len);
    in_vd = 3'(d); in_vs1 = 3'(s1); in_vs2 = 3'(s2); in_masked = msk;
    model(op, wc, len, d, s1, s2, msk);
    @(negedge clk);
    in_valid = 0;
    for (int k = 1; k <= n + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (disturb && k == 1) begin
        in_valid = 1; in_op = ~op; in_vd = 3'd7; in_vs1 = 3'd0; in_vs2 = 3'd0; in_vlen = 8'd32;
        tp_we = 1; tp_reg = 3'd7; tp_word = 5'd0; tp_wdata = 64'hDEAD_BEEF_0BAD_F00D;
      end
      if (disturb && k == 2) tp_we = 0;
      if (disturb && k == n) begin
        in_valid = 0; tp_we = 0;
      end
      if (k <= n) begin
        chk(in_ready === 1'b0, "R7", 64'(in_ready), 64'd0);
        chk(done === 1'b0, "R6", 64'(done), 64'd0);
      end else begin
        chk(done === 1'b1, "R6", 64'(done), 64'd1);
        chk(in_ready === 1'b1, "R7", 64'(in_ready), 64'd1);
      end
    end
    @(negedge clk);
    chk(done === 1'b0, "R6", 64'(done), 64'd0);
    sweep(req);
  endtask

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R7 reset", 64'(in_ready), 64'd1);
    chk(done === 1'b0, "R6 reset", 64'(done), 64'd0);
    rst_n = 1;
    for (int r = 0; r < 6; r++)
      for (int w = 0; w < 32; w++) begin
        v = 64'h9E37_79B9_7F4A_7C15 * 64'(r * 32 + w + 1);
        v = v ^ (v >> 29) ^ 64'(r * 977 + w);
        tp_write(r, w, v);
      end
    for (int w = 0; w < 32; w++) tp_write(6, w, 64'h0001_0001_0001_0001);
    for (int w = 0; w < 32; w++) tp_write(7, w, 64'hFFFF_FFFF_FFFF_FFFF);
    flag_write(128'hA5C3_0FF0_9669_1E2D_F00F_33CC_5AA5_C31E);
    sweep("R8");

    run(0, 2, 32, 0, 1, 2, 0, 0, "R1");
    run(1, 1, 64, 3, 4, 5, 0, 0, "R1");
    run(0, 0, 128, 2, 7, 6, 0, 0, "R2");
    run(0, 2, 32, 5, 7, 6, 0, 1, "R8");
    run(0, 0, 200, 1, 0, 4, 0, 0, "R3");
    run(1, 1, 37, 4, 3, 1, 1, 0, "R4");
    run(1, 0, 77, 6, 2, 5, 1, 1, "R5");
    run(0, 1, 0, 0, 1, 2, 0, 0, "R6");
    run(0, 3, 10, 1, 1, 3, 0, 0, "R9");
    run(1, 2, 3, 2, 2, 7, 0, 1, "R4");
    flag_write(128'h0);
    run(0, 0, 20, 3, 3, 4, 1, 0, "R5");
    flag_write('1);
    run(1, 1, 255, 0, 0, 0, 1, 0, "R3");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule